// File: doc/BRIEF.md
# Framebuffer Rectangle Copy Engine

This block moves a rectangle of 16-bit pixels from one place in a framebuffer to another. A command arrives as three 32-bit words (source corner, destination corner, extent), together with a flag that forces the top bit of every pixel written. The engine runs on its own through a single-port framebuffer request channel. It copies one row at a time, and splits each row into chunks that are staged in an internal line buffer. Every pixel of a chunk is read before any pixel of that chunk is written. Both coordinates wrap at the edges of the framebuffer, so a rectangle that runs off the right or bottom edge continues at column 0 or row 0.

The framebuffer request channel is valid/ready. While `fb_req_valid` is high and `fb_req_ready` is low, the engine keeps `fb_req_addr`, `fb_req_we` and `fb_req_wdata` unchanged. A request is accepted on a clock edge where both are high. The memory answers each accepted read with exactly one `fb_rsp_valid` beat, no earlier than the cycle after acceptance and in order of acceptance. The response side has no back-pressure. Writes get no response. The address is the row index times the row width plus the column index.

When the copy finishes, the engine pulses `done` for one cycle. When pixels were actually written, it also raises `dirty_valid` in the same cycle and presents the destination rectangle on the `dirty_*` outputs, so that caches covering that area can be refreshed.

Top module: `rcopy_engine`

## Requirements
- R1: Position words carry the column in bits X_BITS-1:0 and the row in bits 16+Y_BITS-1:16 (defaults 9:0 and 24:16). All other bits of the position and size words are ignored.
- R2: The size word carries the width in bits X_BITS-1:0 and the height in bits 16+Y_BITS-1:16. A zero field means the largest extent, so widths run from 1 to 2^X_BITS (1024) and heights from 1 to 2^Y_BITS (512).
- R3: If source and destination positions are equal and `mask_set` is 0, the command finishes with no framebuffer request, `done` pulses in the cycle after the start is accepted, and `dirty_valid` stays low.
- R4: Rows are copied top to bottom. Each row is copied left to right in chunks of up to CHUNK pixels (default 128), and every read of a chunk completes before its first write. The resulting framebuffer contents follow this chunked order exactly, including for overlapping rectangles.
- R5: Source and destination columns wrap modulo 2^X_BITS, and rows wrap modulo 2^Y_BITS.
- R6: When `mask_set` was 1 at start, every pixel written has bit 15 set to 1. Otherwise the pixel is written unchanged.
- R7: `done` is high for exactly one cycle per accepted command. `dirty_valid` is high only together with `done`, and for a command that wrote pixels it shows the destination column, row, width and height.
- R8: A `start` that arrives while `busy` is high is ignored. It does not change the copy in progress and does not cause a later command.
- R9: A framebuffer request held by low `fb_req_ready` keeps its valid, address, write enable and write data stable until it is accepted.
- R10: After reset the engine is idle: `busy`, `done`, `dirty_valid` and `fb_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| mask_set | input | 1 | Force bit 15 of written pixels |
| prm_src | input | 32 | Source position word |
| prm_dst | input | 32 | Destination position word |
| prm_size | input | 32 | Width and height word |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dirty_valid | output | 1 | Destination rectangle was written |
| dirty_x | output | X_BITS | Destination column |
| dirty_y | output | Y_BITS | Destination row |
| dirty_w | output | X_BITS+1 | Destination width |
| dirty_h | output | Y_BITS+1 | Destination height |
| fb_req_valid | output | 1 | Framebuffer request valid |
| fb_req_ready | input | 1 | Framebuffer accepts request |
| fb_req_we | output | 1 | 1 = write, 0 = read |
| fb_req_addr | output | X_BITS+Y_BITS | Row * 2^X_BITS + column |
| fb_req_wdata | output | 16 | Write pixel (zero during reads) |
| fb_rsp_valid | input | 1 | Read data beat |
| fb_rsp_data | input | 16 | Read pixel |

## Verification
The copy is swept over a reduced framebuffer of 16 x 8 pixels with 4-pixel chunks. Source corners sit both well inside and at the far edges, and destinations are shifted one or two pixels left or right or more than a chunk away, on the same row or on rows further down. Small shifts separate the chunked order from an ideal overlapping move in both directions. Edge corners with wide or tall extents show whether columns and rows wrap. Widths of 1, exactly one chunk, a chunk plus a remainder, and the zero-coded maximum exercise the chunk boundary and the size decoding. Mixed mask settings, position and size words padded with junk bits, equal source and destination with and without the mask, and a second start issued mid-copy separate the no-op shortcut, the field extraction and the busy rule from the ordinary copy path.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FIN
  } rc_state_e;

  localparam int unsigned POS_Y_LSB = 16;
  localparam int unsigned PIX_W     = 16;
endpackage

// File: rtl/rcopy_decode.sv
module rcopy_decode
  import rcopy_pkg::*;
#(
  parameter int unsigned X_BITS = 10,
  parameter int unsigned Y_BITS = 9,
  localparam int unsigned CW = X_BITS + 1,
  localparam int unsigned RW = Y_BITS + 1
) (
  input  logic [31:0]       src_word,
  input  logic [31:0]       dst_word,
  input  logic [31:0]       size_word,
  output logic [X_BITS-1:0] src_x,
  output logic [Y_BITS-1:0] src_y,
  output logic [X_BITS-1:0] dst_x,
  output logic [Y_BITS-1:0] dst_y,
  output logic [CW-1:0]     width,
  output logic [RW-1:0]     height,
  output logic              same_pos
);
  logic [X_BITS-1:0] w_fld;
  logic [Y_BITS-1:0] h_fld;
  logic              unused_bits;

  assign src_x = src_word[X_BITS-1:0];
  assign dst_x = dst_word[X_BITS-1:0];
  assign src_y = src_word[POS_Y_LSB +: Y_BITS];
  assign dst_y = dst_word[POS_Y_LSB +: Y_BITS];

  assign w_fld = size_word[X_BITS-1:0];
  assign h_fld = size_word[POS_Y_LSB +: Y_BITS];

  // zero field encodes the full extent: top bit set, low bits zero
  assign width  = {(w_fld == '0), w_fld};
  assign height = {(h_fld == '0), h_fld};

  assign same_pos = (src_x == dst_x) && (src_y == dst_y);

  assign unused_bits = ^{src_word, dst_word, size_word};
endmodule

// File: rtl/rcopy_linebuf.sv
module rcopy_linebuf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/rcopy_seq.sv
module rcopy_seq
  import rcopy_pkg::*;
#(
  parameter int unsigned X_BITS = 10,
  parameter int unsigned Y_BITS = 9,
  parameter int unsigned CHUNK  = 128,
  localparam int unsigned CW  = X_BITS + 1,
  localparam int unsigned RW  = Y_BITS + 1,
  localparam int unsigned NW  = $clog2(CHUNK) + 1,
  localparam int unsigned LBW = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mask_set,
  input  logic [X_BITS-1:0] src_x,
  input  logic [Y_BITS-1:0] src_y,
  input  logic [X_BITS-1:0] dst_x,
  input  logic [Y_BITS-1:0] dst_y,
  input  logic [CW-1:0]     width,
  input  logic [RW-1:0]     height,
  input  logic              same_pos,
  output logic              busy,
  output logic              done,
  output logic              dirty_valid,
  output logic [X_BITS-1:0] dirty_x,
  output logic [Y_BITS-1:0] dirty_y,
  output logic [CW-1:0]     dirty_w,
  output logic [RW-1:0]     dirty_h,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [X_BITS-1:0] req_col,
  output logic [Y_BITS-1:0] req_row,
  input  logic              rsp_valid,
  output logic              lb_we,
  output logic [LBW-1:0]    lb_widx,
  output logic [LBW-1:0]    lb_ridx,
  output logic              mask_on
);
  rc_state_e         state_q;
  logic [X_BITS-1:0] sx_q, dx_q;
  logic [Y_BITS-1:0] sy_q, dy_q;
  logic [CW-1:0]     w_q;
  logic [RW-1:0]     h_q;
  logic              mask_q, upd_q;
  logic [Y_BITS-1:0] row_q;
  logic [CW-1:0]     col_q;
  logic [NW-1:0]     rd_iss_q, rd_got_q, wr_iss_q;

  logic [CW-1:0]     rem;
  logic [NW-1:0]     n_chunk;
  logic [NW-1:0]     idx;
  logic [X_BITS-1:0] base_x;
  logic [Y_BITS-1:0] base_y;
  logic              in_read, in_write;
  logic              rd_fire, last_rsp, last_wr, row_end, last_row, noop;

  assign in_read  = (state_q == ST_READ);
  assign in_write = (state_q == ST_WRITE);

  // pixels in the current chunk: the rest of the row, capped at CHUNK
  assign rem     = w_q - col_q;
  assign n_chunk = (rem > CW'(CHUNK)) ? NW'(CHUNK) : NW'(rem);

  assign req_valid = (in_read && (rd_iss_q != n_chunk)) || in_write;
  assign req_we    = in_write;
  assign rd_fire   = in_read && (rd_iss_q != n_chunk) && req_ready;

  assign idx     = in_write ? wr_iss_q : rd_iss_q;
  assign base_x  = in_write ? dx_q : sx_q;
  assign base_y  = in_write ? dy_q : sy_q;
  assign req_col = base_x + col_q[X_BITS-1:0] + X_BITS'(idx);
  assign req_row = base_y + row_q;

  assign lb_we   = in_read && rsp_valid;
  assign lb_widx = rd_got_q[LBW-1:0];
  assign lb_ridx = wr_iss_q[LBW-1:0];

  assign last_rsp = lb_we && (rd_got_q == n_chunk - NW'(1));
  assign last_wr  = in_write && req_ready && (wr_iss_q == n_chunk - NW'(1));
  assign row_end  = ((col_q + CW'(n_chunk)) == w_q);
  assign last_row = (row_q == Y_BITS'(h_q - RW'(1)));
  assign noop     = same_pos && !mask_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sx_q     <= '0;
      sy_q     <= '0;
      dx_q     <= '0;
      dy_q     <= '0;
      w_q      <= '0;
      h_q      <= '0;
      mask_q   <= 1'b0;
      upd_q    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      rd_iss_q <= '0;
      rd_got_q <= '0;
      wr_iss_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            sx_q     <= src_x;
            sy_q     <= src_y;
            dx_q     <= dst_x;
            dy_q     <= dst_y;
            w_q      <= width;
            h_q      <= height;
            mask_q   <= mask_set;
            upd_q    <= !noop;
            row_q    <= '0;
            col_q    <= '0;
            rd_iss_q <= '0;
            rd_got_q <= '0;
            wr_iss_q <= '0;
            state_q  <= noop ? ST_FIN : ST_READ;
          end
        end
        ST_READ: begin
          if (rd_fire) rd_iss_q <= rd_iss_q + NW'(1);
          if (lb_we)   rd_got_q <= rd_got_q + NW'(1);
          if (last_rsp) begin
            wr_iss_q <= '0;
            state_q  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (req_ready) wr_iss_q <= wr_iss_q + NW'(1);
          if (last_wr) begin
            rd_iss_q <= '0;
            rd_got_q <= '0;
            wr_iss_q <= '0;
            if (row_end) begin
              col_q <= '0;
              if (last_row) begin
                state_q <= ST_FIN;
              end else begin
                row_q   <= row_q + Y_BITS'(1);
                state_q <= ST_READ;
              end
            end else begin
              col_q   <= col_q + CW'(n_chunk);
              state_q <= ST_READ;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FIN);
  assign dirty_valid = done && upd_q;
  assign dirty_x     = dx_q;
  assign dirty_y     = dy_q;
  assign dirty_w     = w_q;
  assign dirty_h     = h_q;
  assign mask_on     = mask_q;
endmodule

// File: rtl/rcopy_engine.sv
module rcopy_engine
  import rcopy_pkg::*;
#(
  parameter int unsigned X_BITS = 10,
  parameter int unsigned Y_BITS = 9,
  parameter int unsigned CHUNK  = 128,
  localparam int unsigned CW  = X_BITS + 1,
  localparam int unsigned RW  = Y_BITS + 1,
  localparam int unsigned AW  = X_BITS + Y_BITS,
  localparam int unsigned LBW = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mask_set,
  input  logic [31:0]       prm_src,
  input  logic [31:0]       prm_dst,
  input  logic [31:0]       prm_size,
  output logic              busy,
  output logic              done,
  output logic              dirty_valid,
  output logic [X_BITS-1:0] dirty_x,
  output logic [Y_BITS-1:0] dirty_y,
  output logic [CW-1:0]     dirty_w,
  output logic [RW-1:0]     dirty_h,
  output logic              fb_req_valid,
  input  logic              fb_req_ready,
  output logic              fb_req_we,
  output logic [AW-1:0]     fb_req_addr,
  output logic [15:0]       fb_req_wdata,
  input  logic              fb_rsp_valid,
  input  logic [15:0]       fb_rsp_data
);
  logic [X_BITS-1:0] d_sx, d_dx, req_col;
  logic [Y_BITS-1:0] d_sy, d_dy, req_row;
  logic [CW-1:0]     d_w;
  logic [RW-1:0]     d_h;
  logic              d_same;
  logic              lb_we, mask_on;
  logic [LBW-1:0]    lb_widx, lb_ridx;
  logic [PIX_W-1:0]  lb_rdata;

  rcopy_decode #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_decode (
    .src_word (prm_src),
    .dst_word (prm_dst),
    .size_word(prm_size),
    .src_x    (d_sx),
    .src_y    (d_sy),
    .dst_x    (d_dx),
    .dst_y    (d_dy),
    .width    (d_w),
    .height   (d_h),
    .same_pos (d_same)
  );

  rcopy_seq #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .CHUNK(CHUNK)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mask_set   (mask_set),
    .src_x      (d_sx),
    .src_y      (d_sy),
    .dst_x      (d_dx),
    .dst_y      (d_dy),
    .width      (d_w),
    .height     (d_h),
    .same_pos   (d_same),
    .busy       (busy),
    .done       (done),
    .dirty_valid(dirty_valid),
    .dirty_x    (dirty_x),
    .dirty_y    (dirty_y),
    .dirty_w    (dirty_w),
    .dirty_h    (dirty_h),
    .req_valid  (fb_req_valid),
    .req_ready  (fb_req_ready),
    .req_we     (fb_req_we),
    .req_col    (req_col),
    .req_row    (req_row),
    .rsp_valid  (fb_rsp_valid),
    .lb_we      (lb_we),
    .lb_widx    (lb_widx),
    .lb_ridx    (lb_ridx),
    .mask_on    (mask_on)
  );

  rcopy_linebuf #(.DEPTH(CHUNK), .WIDTH(PIX_W)) u_linebuf (
    .clk    (clk),
    .wr_en  (lb_we),
    .wr_idx (lb_widx),
    .wr_data(fb_rsp_data),
    .rd_idx (lb_ridx),
    .rd_data(lb_rdata)
  );

  assign fb_req_addr  = {req_row, req_col};
  assign fb_req_wdata = fb_req_we ? (lb_rdata | {mask_on, {(PIX_W-1){1'b0}}}) : '0;
endmodule

// File: rtl/rcopy_engine_chk.sv
module rcopy_engine_chk #(
  parameter int unsigned X_BITS = 10,
  parameter int unsigned Y_BITS = 9,
  parameter int unsigned CHUNK  = 128,
  localparam int unsigned CW = X_BITS + 1,
  localparam int unsigned RW = Y_BITS + 1,
  localparam int unsigned AW = X_BITS + Y_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mask_set,
  input logic [31:0]       prm_src,
  input logic [31:0]       prm_dst,
  input logic              busy,
  input logic              done,
  input logic              dirty_valid,
  input logic              fb_req_valid,
  input logic              fb_req_ready,
  input logic              fb_req_we,
  input logic [AW-1:0]     fb_req_addr,
  input logic [15:0]       fb_req_wdata,
  input logic              fb_rsp_valid
);
  logic [15:0] outst_q;
  logic        mask_q, noop_q, accept, pos_eq;
  logic        unused_in;

  assign accept = start && !busy;
  assign pos_eq = (prm_src[X_BITS-1:0] == prm_dst[X_BITS-1:0]) &&
                  (prm_src[16 +: Y_BITS] == prm_dst[16 +: Y_BITS]);
  assign unused_in = ^{prm_src, prm_dst};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
      mask_q  <= 1'b0;
      noop_q  <= 1'b0;
    end else begin
      outst_q <= outst_q
                 + 16'(fb_req_valid && fb_req_ready && !fb_req_we)
                 - 16'(fb_rsp_valid);
      if (accept) begin
        mask_q <= mask_set;
        noop_q <= pos_eq && !mask_set;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req_valid && !fb_req_ready |=> fb_req_valid && $stable(fb_req_addr)
      && $stable(fb_req_we) && $stable(fb_req_wdata));

  assert_reads_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req_valid && fb_req_we |-> outst_q == 16'd0);

  assert_chunk_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= 16'(CHUNK));

  assert_mask_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req_valid && fb_req_we && mask_q |-> fb_req_wdata[15]);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_dirty_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> done);

  assert_noop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && noop_q |-> !fb_req_valid);

  assert_noop_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && noop_q |-> !dirty_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fb_req_valid && !done);
endmodule

bind rcopy_engine rcopy_engine_chk #(
  .X_BITS(X_BITS), .Y_BITS(Y_BITS), .CHUNK(CHUNK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mask_set    (mask_set),
  .prm_src     (prm_src),
  .prm_dst     (prm_dst),
  .busy        (busy),
  .done        (done),
  .dirty_valid (dirty_valid),
  .fb_req_valid(fb_req_valid),
  .fb_req_ready(fb_req_ready),
  .fb_req_we   (fb_req_we),
  .fb_req_addr (fb_req_addr),
  .fb_req_wdata(fb_req_wdata),
  .fb_rsp_valid(fb_rsp_valid)
);

// File: tb/rcopy_engine_tb.sv
module rcopy_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XB = 4;
  localparam int YB = 3;
  localparam int CH = 4;
  localparam int NX = 1 << XB;
  localparam int NY = 1 << YB;
  localparam int NPIX = NX * NY;
  localparam logic [31:0] JUNK = 32'hFFF8_FFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mask_set = 1'b0;
  logic [31:0] prm_src = '0, prm_dst = '0, prm_size = '0;
  logic busy, done, dirty_valid;
  logic [XB-1:0] dirty_x;
  logic [YB-1:0] dirty_y;
  logic [XB:0]   dirty_w;
  logic [YB:0]   dirty_h;
  logic fb_req_valid, fb_req_ready, fb_req_we;
  logic [XB+YB-1:0] fb_req_addr;
  logic [15:0] fb_req_wdata;
  logic fb_rsp_valid = 1'b0;
  logic [15:0] fb_rsp_data = '0;

  logic [15:0] mem [NPIX];
  logic [15:0] exp_mem [NPIX];
  logic [7:0] lfsr = 8'hA5;
  logic fill_req = 1'b0;
  int fill_seed = 0;
  int acc_cnt = 0;
  int n_cmp = 0, n_bad = 0;
  int cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcopy_engine #(.X_BITS(XB), .Y_BITS(YB), .CHUNK(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_set(mask_set),
    .prm_src(prm_src), .prm_dst(prm_dst), .prm_size(prm_size),
    .busy(busy), .done(done), .dirty_valid(dirty_valid),
    .dirty_x(dirty_x), .dirty_y(dirty_y), .dirty_w(dirty_w), .dirty_h(dirty_h),
    .fb_req_valid(fb_req_valid), .fb_req_ready(fb_req_ready), .fb_req_we(fb_req_we),
    .fb_req_addr(fb_req_addr), .fb_req_wdata(fb_req_wdata),
    .fb_rsp_valid(fb_rsp_valid), .fb_rsp_data(fb_rsp_data)
  );

  function automatic logic [15:0] pat(int i, int seed);
    return 16'((i * 113 + seed * 29 + 7) & 32'h7FFF);
  endfunction

  // framebuffer model: back-pressure from an LFSR, read data one cycle after acceptance
  assign fb_req_ready = (lfsr[1:0] != 2'b00);
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    fb_rsp_valid <= 1'b0;
    if (fill_req) begin
      for (int i = 0; i < NPIX; i++) mem[i] <= pat(i, fill_seed);
    end else if (fb_req_valid && fb_req_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (fb_req_we) mem[fb_req_addr] <= fb_req_wdata;
      else begin
        fb_rsp_valid <= 1'b1;
        fb_rsp_data  <= mem[fb_req_addr];
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total == 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish (act=%0d cycles, exp<190000)", cyc_total);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // chunked row-by-row copy on the expected image
  task automatic model_copy(int sx, int sy, int dx, int dy, int w, int h, bit m);
    logic [15:0] tmp [CH];
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c += CH) begin
        int n = (w - c > CH) ? CH : (w - c);
        for (int i = 0; i < n; i++)
          tmp[i] = exp_mem[((sy + r) % NY) * NX + (sx + c + i) % NX];
        for (int i = 0; i < n; i++)
          exp_mem[((dy + r) % NY) * NX + (dx + c + i) % NX] = tmp[i] | (m ? 16'h8000 : 16'h0);
      end
    end
  endtask

  task automatic do_fill(int seed);
    @(negedge clk);
    fill_seed = seed;
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    for (int i = 0; i < NPIX; i++) exp_mem[i] = pat(i, seed);
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < NPIX; i++)
      if (mem[i] !== exp_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s pixel %0d", tag, first), mem[first], exp_mem[first]);
  endtask

  // wait for done at negedges; returns cycles waited
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_copy(int sx, int sy, int dx, int dy, int wf, int hf, bit m,
                          bit junk, int seed, input string tag);
    int w = (wf == 0) ? NX : wf;
    int h = (hf == 0) ? NY : hf;
    bit noop = (sx == dx) && (sy == dy) && !m;
    int cyc, acc0;
    logic [31:0] jw = junk ? JUNK : 32'h0;
    do_fill(seed);
    model_copy(sx, sy, dx, dy, w, h, m);
    acc0 = acc_cnt;
    prm_src  = (32'(sy) << 16) | 32'(sx) | jw;
    prm_dst  = (32'(dy) << 16) | 32'(dx) | jw;
    prm_size = (32'(hf) << 16) | 32'(wf) | jw;
    mask_set = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(done === 1'b1, {tag, " R7 done seen"}, done, 1);
    chk(dirty_valid === !noop, {tag, " R7 dirty_valid"}, dirty_valid, !noop);
    if (!noop)
      chk(dirty_x == XB'(dx) && dirty_y == YB'(dy) && dirty_w == (XB+1)'(w) && dirty_h == (YB+1)'(h),
          {tag, " R7 R2 dirty rect"}, {dirty_x, dirty_y, dirty_w, dirty_h},
          {XB'(dx), YB'(dy), (XB+1)'(w), (YB+1)'(h)});
    else begin
      chk(cyc == 0, {tag, " R3 noop latency"}, cyc, 0);
      chk(acc_cnt == acc0, {tag, " R3 no access"}, acc_cnt - acc0, 0);
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, {tag, " R7 done one cycle"}, {done, busy}, 0);
    cmp_mem({tag, " R4 R5 R6 image"});
  endtask

  initial begin
    int seed = 1;
    int cyc;
    int acc1;
    int late_done;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && dirty_valid === 1'b0 && fb_req_valid === 1'b0,
        "R10 reset state", {busy, done, dirty_valid, fb_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && fb_req_valid === 1'b0, "R10 idle after reset", {busy, fb_req_valid}, 0);

    // main sweep: corners, shifts, rows, extents
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int dd = 0; dd < 3; dd++)
          for (int e = 0; e < 2; e++)
            for (int wi = 0; wi < 4; wi++)
              for (int hi = 0; hi < 3; hi++) begin
                int sx = a ? 13 : 0;
                int sy = b ? 6 : 0;
                int delta = (dd == 0) ? 1 : (dd == 1) ? -2 : 6;
                int dx = (sx + delta + NX) % NX;
                int dy = e ? (sy + 3) % NY : sy;
                int wf = (wi == 0) ? 1 : (wi == 1) ? 4 : (wi == 2) ? 6 : 0;
                int hf = (hi == 0) ? 1 : (hi == 1) ? 3 : 0;
                bit m = (wi + hi + dd) % 2 == 1;
                bit junk = (a ^ e) == 1;
                run_copy(sx, sy, dx, dy, wf, hf, m, junk, seed,
                         $sformatf("sweep R1 R2 s(%0d,%0d) d(%0d,%0d) %0dx%0d m%0d", sx, sy, dx, dy, wf, hf, m));
                seed++;
              end

    // overlap in both directions across several chunks, full width (R4)
    run_copy(0, 2, 2, 2, 0, 2, 1'b0, 1'b0, 500, "R4 right overlap");
    run_copy(3, 1, 1, 1, 0, 2, 1'b0, 1'b0, 501, "R4 left overlap");
    run_copy(0, 0, 0, 1, 5, 0, 1'b0, 1'b0, 502, "R4 downward overlap");
    // wrap in both axes (R5)
    run_copy(14, 7, 11, 5, 7, 4, 1'b0, 1'b0, 503, "R5 wrap both");
    // no-op and mask on identical positions (R3, R6)
    run_copy(5, 3, 5, 3, 6, 2, 1'b0, 1'b0, 504, "R3 noop");
    run_copy(5, 3, 5, 3, 6, 2, 1'b0, 1'b1, 505, "R3 R1 noop junk");
    run_copy(5, 3, 5, 3, 6, 2, 1'b1, 1'b0, 506, "R6 mask in place");

    // start while busy is ignored (R8)
    do_fill(600);
    model_copy(1, 1, 9, 4, 6, 3, 1'b0);
    prm_src = (32'd1 << 16) | 32'd1;
    prm_dst = (32'd4 << 16) | 32'd9;
    prm_size = (32'd3 << 16) | 32'd6;
    mask_set = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busy === 1'b1, "R8 busy during copy", busy, 1);
    prm_src = 32'd0;
    prm_dst = (32'd7 << 16) | 32'd3;
    prm_size = 32'd0;
    mask_set = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk(dirty_x == XB'(9) && dirty_y == YB'(4), "R8 rect of first command", {dirty_x, dirty_y}, {XB'(9), YB'(4)});
    acc1 = acc_cnt;
    late_done = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || busy) late_done++;
    end
    chk(late_done == 0 && acc_cnt == acc1, "R8 no second command", late_done, 0);
    cmp_mem("R8 image of first command");

    summary();
    $finish;
  end
endmodule